// File: doc/BRIEF.md
# Rename Stage Stall Controller

This block is the per-cycle control of a register-rename pipeline stage. Each cycle it looks at the instructions waiting to be renamed: first the ones held in its own skid buffer, then the group arriving from decode. It decides how many of them, oldest first, may go on to the back end. Instructions that cannot go on are kept in the skid buffer in order. The block also produces a stall signal that holds decode back, and it reports its control state and the reason for any resource block.

Three things limit how far the stage advances: the room left in the reorder buffer, the issue queue and the load/store queue; stall requests from the execute and commit stages; and serializing instructions. The room in each structure is the free count it reports, less the instructions already sent but not yet counted. A barrier instruction waits at the head until the reorder buffer is empty and nothing is in flight. An instruction flagged serialize-after makes the next instruction behave like a barrier. A squash empties the skid buffer and clears the pending serialize mark. Mapping registers is not part of this block.

Decode sees the stall one cycle late, so it may deliver one more group in the first cycle the stall is high. For this reason the skid buffer holds two groups.

Top module: `rename_stall_ctrl`

## Requirements
- R1: After reset the state is Idle (code 1), the full cause is 0, the decode stall is low, and nothing passes while no instruction is offered.
- R2: With no barrier, stall or squash, the pass count equals the smallest of: the number of candidate instructions, WIDTH, and the room left in each of the three structures. The room in a structure is its free count minus the in-flight count, or 0 if that difference is negative.
- R3: When a structure's room stops the pass, the next state is Blocked (code 4) with a full cause. The cause is 1 for the reorder buffer, 2 for the issue queue and 3 for the load/store queue, taken in that priority order among the structures whose room is not greater than the pass count. The cause is nonzero only in Blocked.
- R4: While the execute stall or the commit stall input is high, nothing passes, and the next state is Blocked with cause 0.
- R5: Candidates that do not pass stay in the skid buffer and are offered first on the next cycle, oldest first, ahead of new arrivals. Pass tag slot k (bits k*TAG_W upward) carries the k-th passed instruction.
- R6: When WIDTH limits the pass and instructions are left over, the next state is Unblocking (code 5). Running (code 0) or Idle is entered only when every candidate has passed, which leaves the skid buffer empty.
- R7: A barrier instruction passes only from candidate slot 0, and only while the reorder buffer is empty and the in-flight count is 0. Otherwise it is held at the head and the next state is SerializeStall (code 6).
- R8: The instruction right after a passed serialize-after instruction is treated as a barrier. This applies in the same cycle, or to the next one to arrive if none is waiting. The mark is used up once that instruction passes.
- R9: A squash moves the state to StartSquash (code 2) for exactly one cycle, then to Squashing (code 3) while the squash stays high, then to Running. In all of these cycles nothing passes, arriving instructions are dropped, and the skid buffer and the serialize mark are cleared.
- R10: The decode stall is high exactly when the state is Blocked, Unblocking or SerializeStall.
- R11: When all candidates pass, the next state is Running if there was at least one candidate and Idle if there were none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | WIDTH | Valid mask for the decode group; valid slots start at slot 0 with no gaps |
| inBarrier | input | WIDTH | Barrier flag for each decode slot |
| inSerAfter | input | WIDTH | Serialize-after flag for each decode slot |
| inTag | input | WIDTH*TAG_W | Identifier for each decode slot |
| freeRob | input | CNT_W | Free reorder buffer entries |
| freeIq | input | CNT_W | Free issue queue entries |
| freeLsq | input | CNT_W | Free load/store queue entries |
| inFlight | input | CNT_W | Instructions sent but not yet counted by the back end |
| robEmpty | input | 1 | Reorder buffer is empty |
| stallExec | input | 1 | Stall request from the execute stage |
| stallCommit | input | 1 | Stall request from the commit stage |
| squash | input | 1 | Squash request |
| passCount | output | $clog2(WIDTH+1) | Instructions passed this cycle |
| passTag | output | WIDTH*TAG_W | Identifiers of the passed instructions, oldest in slot 0 |
| decodeStall | output | 1 | Hold request to decode |
| state | output | 3 | Current control state |
| fullCause | output | 2 | Structure that caused the current Blocked state |

## Verification
The resource rule is swept over every combination of three free counts from 0 to 3, in-flight counts of 0 and 1, and groups of one or two instructions. This separates a pass limited by the group size from one limited by each structure, and checks the cause priority whenever several structures are short at once. Directed sequences then follow instructions through the skid buffer across stalls from each stage, including the late group from decode. This separates the Unblocking drain from a direct return to Running. Barriers in slot 0 and slot 1, serialize-after marks applied to the same group and to a later arrival, and squashes taken from a blocked state show whether held instructions keep their order, and whether a squash really discards them and clears the mark.

// File: rtl/rn_pkg.sv
package rn_pkg;

  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_IDLE     = 3'd1,
    ST_SQ_START = 3'd2,
    ST_SQ_WAIT  = 3'd3,
    ST_BLOCK    = 3'd4,
    ST_UNBLOCK  = 3'd5,
    ST_SER      = 3'd6
  } rnState_e;

  typedef enum logic [1:0] {
    FULL_NONE = 2'd0,
    FULL_ROB  = 2'd1,
    FULL_IQ   = 2'd2,
    FULL_LSQ  = 2'd3
  } fullCause_e;

  // strobes from the control to the skid datapath
  typedef struct packed {
    logic       flush;    // drop all held and arriving instructions
    logic [7:0] advance;  // number of candidates leaving this cycle
  } skidCtl_t;

endpackage

// File: rtl/rn_skid.sv
module rn_skid
  import rn_pkg::*;
#(
  parameter int WIDTH = 2,
  parameter int DEPTH = 4,
  parameter int TAG_W = 4,
  parameter int CW    = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  skidCtl_t               ctl,
  input  logic [WIDTH-1:0]       inValid,
  input  logic [WIDTH-1:0]       inBarrier,
  input  logic [WIDTH-1:0]       inSerAfter,
  input  logic [WIDTH*TAG_W-1:0] inTag,
  output logic [CW-1:0]          candCount,
  output logic [WIDTH-1:0]       candBar,
  output logic [WIDTH-1:0]       candSer,
  output logic [WIDTH*TAG_W-1:0] passTag,
  output logic [CW-1:0]          skidCount
);

  localparam int CAND = DEPTH + WIDTH;

  logic [DEPTH-1:0] qBar, qSer, nBar, nSer;
  logic [TAG_W-1:0] qTag [DEPTH];
  logic [TAG_W-1:0] nTag [DEPTH];
  logic [CW-1:0]    qCnt, nCnt, inCount, leftover;
  logic [CAND-1:0]  cBar, cSer;
  logic [TAG_W-1:0] cTag [CAND];

  // candidate window: held entries first, then the arriving group
  always_comb begin
    inCount   = CW'($countones(inValid));
    candCount = qCnt + inCount;
    cBar = '0;
    cSer = '0;
    for (int i = 0; i < CAND; i++) cTag[i] = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i) < qCnt) begin
        cBar[i] = qBar[i];
        cSer[i] = qSer[i];
        cTag[i] = qTag[i];
      end
    end
    for (int i = 0; i < CAND; i++) begin
      for (int j = 0; j < WIDTH; j++) begin
        if (inValid[j] && (CW'(i) == qCnt + CW'(j))) begin
          cBar[i] = inBarrier[j];
          cSer[i] = inSerAfter[j];
          cTag[i] = inTag[j*TAG_W +: TAG_W];
        end
      end
    end
    for (int i = 0; i < WIDTH; i++) begin
      candBar[i] = cBar[i];
      candSer[i] = cSer[i];
      passTag[i*TAG_W +: TAG_W] = cTag[i];
    end
  end

  // shift the window by the number that left
  always_comb begin
    leftover = candCount - CW'(ctl.advance);
    if (ctl.flush) nCnt = '0;
    else if (leftover > CW'(DEPTH)) nCnt = CW'(DEPTH);
    else nCnt = leftover;
    nBar = '0;
    nSer = '0;
    for (int i = 0; i < DEPTH; i++) begin
      nTag[i] = '0;
      for (int k = 0; k <= WIDTH; k++) begin
        if (ctl.advance == 8'(k)) begin
          nBar[i] = cBar[i+k];
          nSer[i] = cSer[i+k];
          nTag[i] = cTag[i+k];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qCnt <= '0;
      qBar <= '0;
      qSer <= '0;
      for (int i = 0; i < DEPTH; i++) qTag[i] <= '0;
    end else begin
      qCnt <= nCnt;
      qBar <= nBar;
      qSer <= nSer;
      for (int i = 0; i < DEPTH; i++) qTag[i] <= nTag[i];
    end
  end

  assign skidCount = qCnt;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.flush |-> (candCount - CW'(ctl.advance)) <= CW'(DEPTH)); // R5

endmodule

// File: rtl/rn_ctrl.sv
module rn_ctrl
  import rn_pkg::*;
#(
  parameter int WIDTH = 2,
  parameter int CNT_W = 4,
  parameter int CW    = 3,
  parameter int PW    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] freeRob,
  input  logic [CNT_W-1:0] freeIq,
  input  logic [CNT_W-1:0] freeLsq,
  input  logic [CNT_W-1:0] inFlight,
  input  logic             robEmpty,
  input  logic             stallExec,
  input  logic             stallCommit,
  input  logic             squash,
  input  logic [CW-1:0]    candCount,
  input  logic [WIDTH-1:0] candBar,
  input  logic [WIDTH-1:0] candSer,
  output skidCtl_t         ctl,
  output logic [PW-1:0]    passCount,
  output rnState_e         stateQ,
  output fullCause_e       causeQ
);

  logic [CNT_W-1:0] availR, availI, availL;
  logic [WIDTH-1:0] prevSer;
  logic [PW-1:0]    n;
  logic             go, resOk, barOk, stopRes, extStall, squashFlow;
  logic             serNext, serNextN;
  rnState_e         stateN;
  fullCause_e       causeN;

  always_comb begin
    availR  = (freeRob > inFlight) ? freeRob - inFlight : '0;
    availI  = (freeIq  > inFlight) ? freeIq  - inFlight : '0;
    availL  = (freeLsq > inFlight) ? freeLsq - inFlight : '0;
    // slot i is serialized by the slot before it, slot 0 by the stored mark
    prevSer = WIDTH'({candSer, serNext});
    extStall   = stallExec | stallCommit;
    squashFlow = squash | (stateQ == ST_SQ_START) | (stateQ == ST_SQ_WAIT);
    n       = '0;
    go      = 1'b1;
    stopRes = 1'b0;
    resOk   = 1'b0;
    barOk   = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      resOk = (availR > CNT_W'(i)) && (availI > CNT_W'(i)) && (availL > CNT_W'(i));
      barOk = !(candBar[i] | prevSer[i]) || ((i == 0) && robEmpty && (inFlight == '0));
      if (go) begin
        if ((CW'(i) < candCount) && resOk && barOk) n = n + 1'b1;
        else begin
          go      = 1'b0;
          stopRes = !resOk;
        end
      end
    end
    if (squashFlow || extStall) n = '0;
  end

  always_comb begin
    causeN   = FULL_NONE;
    serNextN = serNext;
    for (int i = 0; i < WIDTH; i++) begin
      if (n == PW'(i + 1)) serNextN = candSer[i];
    end
    if (squashFlow) serNextN = 1'b0;
    if (stateQ == ST_SQ_START)      stateN = ST_SQ_WAIT;
    else if (stateQ == ST_SQ_WAIT)  stateN = squash ? ST_SQ_WAIT : ST_RUN;
    else if (squash)                stateN = ST_SQ_START;
    else if (extStall)              stateN = ST_BLOCK;
    else if (CW'(n) == candCount)   stateN = (candCount == '0) ? ST_IDLE : ST_RUN;
    else if (n >= PW'(WIDTH))       stateN = ST_UNBLOCK;
    else if (stopRes) begin
      stateN = ST_BLOCK;
      if (availR <= CNT_W'(n))      causeN = FULL_ROB;
      else if (availI <= CNT_W'(n)) causeN = FULL_IQ;
      else                          causeN = FULL_LSQ;
    end
    else                            stateN = ST_SER;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      causeQ  <= FULL_NONE;
      serNext <= 1'b0;
    end else begin
      stateQ  <= stateN;
      causeQ  <= causeN;
      serNext <= serNextN;
    end
  end

  assign passCount   = n;
  assign ctl.flush   = squashFlow;
  assign ctl.advance = 8'(n);

  AST_SQUASH_ENTER: assert property (@(posedge clk) disable iff (!rstN)
    squash && (stateQ != ST_SQ_START) && (stateQ != ST_SQ_WAIT) |=> stateQ == ST_SQ_START); // R9
  AST_SQUASH_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stateQ == ST_SQ_START |=> stateQ == ST_SQ_WAIT); // R9
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    extStall && !squashFlow |=> (stateQ == ST_BLOCK) && (causeQ == FULL_NONE)); // R4
  AST_BARRIER_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (passCount != '0) && (candBar[0] || serNext) |-> robEmpty && (inFlight == '0)); // R7

endmodule

// File: rtl/rename_stall_ctrl.sv
module rename_stall_ctrl
  import rn_pkg::*;
#(
  parameter int WIDTH = 2,
  parameter int DEPTH = 2 * WIDTH,
  parameter int TAG_W = 4,
  parameter int CNT_W = 4,
  localparam int CW   = $clog2(DEPTH + WIDTH + 1),
  localparam int PW   = $clog2(WIDTH + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [WIDTH-1:0]       inValid,
  input  logic [WIDTH-1:0]       inBarrier,
  input  logic [WIDTH-1:0]       inSerAfter,
  input  logic [WIDTH*TAG_W-1:0] inTag,
  input  logic [CNT_W-1:0]       freeRob,
  input  logic [CNT_W-1:0]       freeIq,
  input  logic [CNT_W-1:0]       freeLsq,
  input  logic [CNT_W-1:0]       inFlight,
  input  logic                   robEmpty,
  input  logic                   stallExec,
  input  logic                   stallCommit,
  input  logic                   squash,
  output logic [PW-1:0]          passCount,
  output logic [WIDTH*TAG_W-1:0] passTag,
  output logic                   decodeStall,
  output logic [2:0]             state,
  output logic [1:0]             fullCause
);

  skidCtl_t         ctl;
  logic [CW-1:0]    candCount, skidCount;
  logic [WIDTH-1:0] candBar, candSer;
  rnState_e         stateQ;
  fullCause_e       causeQ;

  rn_skid #(.WIDTH(WIDTH), .DEPTH(DEPTH), .TAG_W(TAG_W), .CW(CW)) u_skid (
    .clk, .rstN, .ctl, .inValid, .inBarrier, .inSerAfter, .inTag,
    .candCount, .candBar, .candSer, .passTag, .skidCount
  );

  rn_ctrl #(.WIDTH(WIDTH), .CNT_W(CNT_W), .CW(CW), .PW(PW)) u_ctrl (
    .clk, .rstN, .freeRob, .freeIq, .freeLsq, .inFlight, .robEmpty,
    .stallExec, .stallCommit, .squash, .candCount, .candBar, .candSer,
    .ctl, .passCount, .stateQ, .causeQ
  );

  assign state       = stateQ;
  assign fullCause   = causeQ;
  assign decodeStall = (stateQ == ST_BLOCK) || (stateQ == ST_UNBLOCK) || (stateQ == ST_SER);

  AST_RUN_SKID_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN) || (stateQ == ST_IDLE) |-> skidCount == '0); // R6
  AST_CAUSE_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    causeQ != FULL_NONE |-> stateQ == ST_BLOCK); // R3

endmodule

// File: tb/rename_stall_ctrl_tb.sv
module rename_stall_ctrl_tb;

  localparam int S_RUN = 0, S_IDLE = 1, S_SQS = 2, S_SQW = 3, S_BLK = 4, S_UNB = 5, S_SER = 6;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] inValid, inBarrier, inSerAfter;
  logic [7:0] inTag;
  logic [3:0] freeRob, freeIq, freeLsq, inFlight;
  logic       robEmpty, stallExec, stallCommit, squash;
  logic [1:0] passCount;
  logic [7:0] passTag;
  logic       decodeStall;
  logic [2:0] state;
  logic [1:0] fullCause;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  int pcS;
  int tag0S, tag1S;

  rename_stall_ctrl u_dut (
    .clk, .rstN, .inValid, .inBarrier, .inSerAfter, .inTag, .freeRob, .freeIq,
    .freeLsq, .inFlight, .robEmpty, .stallExec, .stallCommit, .squash,
    .passCount, .passTag, .decodeStall, .state, .fullCause
  );

  always #10 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setIn(int nv, logic [1:0] bar, logic [1:0] ser, int t0, int t1,
                       int fr, int fi, int fl, int inf, bit re, bit se, bit sc, bit sq);
    inValid     = (nv == 0) ? 2'b00 : (nv == 1) ? 2'b01 : 2'b11;
    inBarrier   = bar;
    inSerAfter  = ser;
    inTag       = {4'(t1), 4'(t0)};
    freeRob     = 4'(fr);
    freeIq      = 4'(fi);
    freeLsq     = 4'(fl);
    inFlight    = 4'(inf);
    robEmpty    = re;
    stallExec   = se;
    stallCommit = sc;
    squash      = sq;
  endtask

  task automatic quiet();
    setIn(0, 2'b00, 2'b00, 0, 0, 8, 8, 8, 0, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  // sample the combinational pass outputs, then move to the next falling edge
  task automatic step();
    #5;
    pcS   = int'(passCount);
    tag0S = int'(passTag[3:0]);
    tag1S = int'(passTag[7:4]);
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    quiet();
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    chk("R1 state", int'(state), S_IDLE);
    chk("R1 cause", int'(fullCause), 0);
    chk("R1 stall", int'(decodeStall), 0);
    step();
    chk("R1 pass", pcS, 0);

    // R2 / R3 sweep over room in each structure
    for (int fr = 0; fr < 4; fr++)
      for (int fi = 0; fi < 4; fi++)
        for (int fl = 0; fl < 4; fl++)
          for (int inf = 0; inf < 2; inf++)
            for (int nv = 1; nv < 3; nv++) begin
              int ar, ai, al, cap, ep, ec;
              doReset();
              ar = (fr > inf) ? fr - inf : 0;
              ai = (fi > inf) ? fi - inf : 0;
              al = (fl > inf) ? fl - inf : 0;
              cap = ar; if (ai < cap) cap = ai; if (al < cap) cap = al;
              ep = (nv < cap) ? nv : cap;
              setIn(nv, 2'b00, 2'b00, 5, 9, fr, fi, fl, inf, 1'b1, 1'b0, 1'b0, 1'b0);
              step();
              chk("R2 pass count", pcS, ep);
              if (ep > 0) chk("R5 slot0 tag", tag0S, 5);
              if (ep > 1) chk("R5 slot1 tag", tag1S, 9);
              if (ep == nv) begin
                chk("R11 state after full pass", int'(state), S_RUN);
                chk("R3 cause none", int'(fullCause), 0);
              end else begin
                ec = (ar <= ep) ? 1 : (ai <= ep) ? 2 : 3;
                chk("R3 blocked state", int'(state), S_BLK);
                chk("R3 cause priority", int'(fullCause), ec);
                chk("R10 stall when blocked", int'(decodeStall), 1);
              end
            end

    // R4 execute stall, late decode group, then Unblocking drain
    doReset();
    setIn(2, 2'b00, 2'b00, 1, 2, 8, 8, 8, 0, 1'b1, 1'b1, 1'b0, 1'b0);
    step();
    chk("R4 no pass under stall", pcS, 0);
    chk("R4 blocked", int'(state), S_BLK);
    chk("R4 cause zero", int'(fullCause), 0);
    chk("R10 stall high", int'(decodeStall), 1);
    setIn(2, 2'b00, 2'b00, 3, 4, 8, 8, 8, 0, 1'b1, 1'b1, 1'b0, 1'b0);
    step();
    chk("R4 no pass late group", pcS, 0);
    quiet();
    step();
    chk("R5 oldest pass count", pcS, 2);
    chk("R5 oldest tag0", tag0S, 1);
    chk("R5 oldest tag1", tag1S, 2);
    chk("R6 unblocking", int'(state), S_UNB);
    chk("R10 stall in unblocking", int'(decodeStall), 1);
    step();
    chk("R5 drain count", pcS, 2);
    chk("R5 drain tag0", tag0S, 3);
    chk("R5 drain tag1", tag1S, 4);
    chk("R6 running after drain", int'(state), S_RUN);
    chk("R10 stall low running", int'(decodeStall), 0);
    step();
    chk("R11 idle pass", pcS, 0);
    chk("R11 idle state", int'(state), S_IDLE);

    // R4 commit stall
    setIn(1, 2'b00, 2'b00, 5, 0, 8, 8, 8, 0, 1'b1, 1'b0, 1'b1, 1'b0);
    step();
    chk("R4 commit stall pass", pcS, 0);
    chk("R4 commit stall state", int'(state), S_BLK);
    quiet();
    step();
    chk("R5 held after commit stall", pcS, 1);
    chk("R5 held tag", tag0S, 5);
    chk("R11 running", int'(state), S_RUN);

    // R3 partial pass, then recovery
    setIn(2, 2'b00, 2'b00, 6, 7, 1, 8, 8, 0, 1'b1, 1'b0, 1'b0, 1'b0);
    step();
    chk("R3 partial pass", pcS, 1);
    chk("R3 partial tag", tag0S, 6);
    chk("R3 rob cause", int'(fullCause), 1);
    quiet();
    step();
    chk("R5 leftover passes", pcS, 1);
    chk("R5 leftover tag", tag0S, 7);
    chk("R3 cause cleared", int'(fullCause), 0);

    // R7 barrier in slot 0
    doReset();
    setIn(1, 2'b01, 2'b00, 8, 0, 8, 8, 8, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    step();
    chk("R7 barrier held rob busy", pcS, 0);
    chk("R7 serialize stall", int'(state), S_SER);
    chk("R10 stall in serialize", int'(decodeStall), 1);
    setIn(0, 2'b00, 2'b00, 0, 0, 8, 8, 8, 1, 1'b1, 1'b0, 1'b0, 1'b0);
    step();
    chk("R7 barrier held in flight", pcS, 0);
    chk("R7 still serialize", int'(state), S_SER);
    quiet();
    step();
    chk("R7 barrier released", pcS, 1);
    chk("R7 barrier tag", tag0S, 8);
    chk("R7 running", int'(state), S_RUN);
    // R7 barrier in slot 1
    setIn(2, 2'b10, 2'b00, 9, 10, 8, 8, 8, 0, 1'b1, 1'b0, 1'b0, 1'b0);
    step();
    chk("R7 slot1 barrier stops", pcS, 1);
    chk("R7 slot1 older tag", tag0S, 9);
    chk("R7 slot1 serialize", int'(state), S_SER);
    quiet();
    step();
    chk("R7 slot1 barrier passes", pcS, 1);
    chk("R7 slot1 barrier tag", tag0S, 10);

    // R8 serialize-after in the same group
    setIn(2, 2'b00, 2'b01, 11, 12, 8, 8, 8, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    step();
    chk("R8 same group stop", pcS, 1);
    chk("R8 same group state", int'(state), S_SER);
    quiet();
    step();
    chk("R8 follower passes", pcS, 1);
    chk("R8 follower tag", tag0S, 12);
    // R8 serialize-after marks the next arrival
    setIn(1, 2'b00, 2'b01, 13, 0, 8, 8, 8, 0, 1'b1, 1'b0, 1'b0, 1'b0);
    step();
    chk("R8 lone pass", pcS, 1);
    chk("R11 lone running", int'(state), S_RUN);
    setIn(1, 2'b00, 2'b00, 14, 0, 8, 8, 8, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    step();
    chk("R8 next arrival held", pcS, 0);
    chk("R8 next arrival serialize", int'(state), S_SER);
    quiet();
    step();
    chk("R8 next arrival passes", pcS, 1);
    chk("R8 next arrival tag", tag0S, 14);
    setIn(1, 2'b00, 2'b00, 15, 0, 8, 8, 8, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    step();
    chk("R8 mark used up", pcS, 1);

    // R9 squash from blocked with held instructions
    doReset();
    setIn(2, 2'b00, 2'b00, 1, 2, 8, 8, 8, 0, 1'b1, 1'b1, 1'b0, 1'b0);
    step();
    setIn(0, 2'b00, 2'b00, 0, 0, 8, 8, 8, 0, 1'b1, 1'b0, 1'b0, 1'b1);
    step();
    chk("R9 no pass on squash", pcS, 0);
    chk("R9 start squash", int'(state), S_SQS);
    chk("R10 stall low in squash", int'(decodeStall), 0);
    setIn(2, 2'b00, 2'b00, 3, 4, 8, 8, 8, 0, 1'b1, 1'b0, 1'b0, 1'b1);
    step();
    chk("R9 no pass start", pcS, 0);
    chk("R9 squashing", int'(state), S_SQW);
    setIn(2, 2'b00, 2'b00, 5, 6, 8, 8, 8, 0, 1'b1, 1'b0, 1'b0, 1'b0);
    step();
    chk("R9 no pass squashing", pcS, 0);
    chk("R9 back to running", int'(state), S_RUN);
    quiet();
    step();
    chk("R9 held dropped", pcS, 0);
    chk("R9 idle after flush", int'(state), S_IDLE);
    // R9 squash clears the serialize mark
    setIn(1, 2'b00, 2'b01, 7, 0, 8, 8, 8, 0, 1'b1, 1'b0, 1'b0, 1'b0);
    step();
    setIn(0, 2'b00, 2'b00, 0, 0, 8, 8, 8, 0, 1'b1, 1'b0, 1'b0, 1'b1);
    step();
    quiet();
    step();
    step();
    chk("R9 running after short squash", int'(state), S_RUN);
    setIn(1, 2'b00, 2'b00, 8, 0, 8, 8, 8, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    step();
    chk("R9 mark cleared", pcS, 1);
    chk("R9 mark cleared tag", tag0S, 8);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule